// File: doc/BRIEF.md
# Byte Programming Pulse Sequencer

This block writes one byte at a time into an ultraviolet-erasable or one-time-programmable parallel memory. A host pulses `start` with an address and a data byte. The sequencer then raises the core supply enable and the programming supply enable. It drives the address and data, and it applies a single program strobe of fixed width. Every setup, hold and recovery interval is counted in clock ticks derived from a ticks-per-microsecond parameter.

After each strobe the sequencer releases the data bus and removes the programming supply. It waits for the recovery time and then reads the cell back with chip enable and output enable both low. If the read value matches the byte, the operation ends cleanly. If it differs, the strobe is repeated, up to a fixed number of strobes. When that limit is reached, the operation ends with the error flag set. At the end, `done` pulses for one cycle and both supplies are off.

Top module: `prom_burner`

## Requirements
- R1: After reset, and whenever idle, `vcc_en`=0, `vpp_en`=0, `bus_oe`=0, `mem_ce_n`=1, `mem_oe_n`=1, `busy`=0, `done`=0 and `err`=0 (until the first operation ends).
- R2: `start` is sampled only while idle. `addr` and `wdata` are captured then and shown unchanged on `mem_addr` and `mem_dout` for the whole operation. A `start` seen while `busy`=1 is ignored.
- R3: `vpp_en`=1 only while `vcc_en`=1. In an operation, `vcc_en` is high for exactly SETUP_US×TICKS_PER_US cycles before `vpp_en` first rises. `vcc_en` falls only after `vpp_en` is low.
- R4: Before each strobe, `bus_oe`=1 and `mem_oe_n`=1 with address and data driven, for exactly SETUP_US×TICKS_PER_US cycles with `mem_ce_n`=1.
- R5: Each program strobe (`mem_ce_n`=0 with `mem_oe_n`=1) lasts exactly PULSE_US×TICKS_PER_US cycles, with `vpp_en`=1 and `bus_oe`=1 throughout.
- R6: After each strobe, `bus_oe`=1 and `mem_oe_n`=1 stay for exactly HOLD_US×TICKS_PER_US cycles before `bus_oe` falls.
- R7: `bus_oe` is never 1 while `mem_oe_n`=0. `vpp_en` is low for exactly RECOV_US×TICKS_PER_US cycles, with the bus released, before `mem_oe_n` falls. `vpp_en` is 0 during the read.
- R8: A verify read holds `mem_ce_n`=0 and `mem_oe_n`=0 for ceil(VERIFY_NS×TICKS_PER_US/1000)+1 cycles. `mem_din` is compared with the byte in the last of those cycles.
- R9: On a mismatch the sequencer repeats the setup, strobe, hold, recovery and read, so that at most MAX_TRIES strobes are issued per operation. A match ends the operation after the strobe that produced it.
- R10: At the end, `done`=1 for exactly one cycle. `err`=1 if and only if the final read mismatched. `err` keeps its value until the next accepted `start` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin programming one byte |
| addr | input | ADDR_W | Target address |
| wdata | input | 8 | Byte to program |
| mem_din | input | 8 | Data read from the memory |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_dout | output | 8 | Data to the memory |
| bus_oe | output | 1 | Enables the data bus drivers |
| mem_ce_n | output | 1 | Chip enable / program strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| vcc_en | output | 1 | Core supply enable |
| vpp_en | output | 1 | Programming supply enable |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Final verify mismatched |

## Verification
The assertions assume that `mem_din` reflects the memory only while chip enable and output enable are both low. They also assume that a reset may arrive at any time. They place no constraint on when `start` is raised, because a request arriving during an operation must simply be ignored.

The stimulus draws random addresses and bytes. Each cell gets a random number of strobes it needs before it takes the value, and a random prior content, so some writes must clear bits that cannot be restored. Directed cases cover a write needing exactly the strobe limit, a write needing one more, and an intruding `start` during an operation.

// File: rtl/prom_burner.sv
module prom_burner #(
  parameter int ADDR_W       = 16,
  parameter int TICKS_PER_US = 200,
  parameter int PULSE_US     = 100,
  parameter int SETUP_US     = 1,
  parameter int HOLD_US      = 1,
  parameter int RECOV_US     = 1,
  parameter int VERIFY_NS    = 250,
  parameter int MAX_TRIES    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [7:0]        mem_din,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_dout,
  output logic              bus_oe,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              vcc_en,
  output logic              vpp_en,
  output logic              busy,
  output logic              done,
  output logic              err
);

  localparam int T_SET = SETUP_US * TICKS_PER_US;
  localparam int T_PW  = PULSE_US * TICKS_PER_US;
  localparam int T_HLD = HOLD_US * TICKS_PER_US;
  localparam int T_REC = RECOV_US * TICKS_PER_US;
  localparam int T_VFY = (VERIFY_NS * TICKS_PER_US + 999) / 1000 + 1;
  localparam int T_SUM = T_SET + T_PW + T_HLD + T_REC + T_VFY;
  localparam int TW    = $clog2(T_SUM + 1);
  localparam int NW    = $clog2(MAX_TRIES + 1);

  localparam logic [TW-1:0] L_SET = TW'(T_SET - 1);
  localparam logic [TW-1:0] L_PW  = TW'(T_PW - 1);
  localparam logic [TW-1:0] L_HLD = TW'(T_HLD - 1);
  localparam logic [TW-1:0] L_REC = TW'(T_REC - 1);
  localparam logic [TW-1:0] L_VFY = TW'(T_VFY - 1);
  localparam logic [NW-1:0] N_MAX = NW'(MAX_TRIES);

  typedef enum logic [2:0] {
    S_IDLE, S_VCC, S_SET, S_PULSE, S_HOLD, S_REC, S_VFY
  } st_t;

  st_t             st;
  logic [TW-1:0]   tmr;
  logic [NW-1:0]   tries;
  logic [ADDR_W-1:0] a_q;
  logic [7:0]      d_q;
  logic            match;

  assign match = (mem_din == d_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      tmr   <= '0;
      tries <= '0;
      a_q   <= '0;
      d_q   <= '0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          a_q   <= addr;
          d_q   <= wdata;
          err   <= 1'b0;
          tries <= '0;
          tmr   <= L_SET;
          st    <= S_VCC;
        end
      end else if (tmr != '0) begin
        tmr <= tmr - 1'b1;
      end else begin
        case (st)
          S_VCC:   begin st <= S_SET;   tmr <= L_SET; end
          S_SET:   begin st <= S_PULSE; tmr <= L_PW; tries <= tries + 1'b1; end
          S_PULSE: begin st <= S_HOLD;  tmr <= L_HLD; end
          S_HOLD:  begin st <= S_REC;   tmr <= L_REC; end
          S_REC:   begin st <= S_VFY;   tmr <= L_VFY; end
          S_VFY: begin
            if (match || tries == N_MAX) begin
              st   <= S_IDLE;
              done <= 1'b1;
              err  <= !match;
            end else begin
              st  <= S_SET;
              tmr <= L_SET;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign mem_addr = a_q;
  assign mem_dout = d_q;
  assign busy     = (st != S_IDLE);
  assign vcc_en   = busy;
  assign vpp_en   = (st == S_SET) || (st == S_PULSE) || (st == S_HOLD);
  assign bus_oe   = vpp_en;
  assign mem_ce_n = !((st == S_PULSE) || (st == S_VFY));
  assign mem_oe_n = (st != S_VFY);

endmodule

// File: rtl/prom_burner_chk.sv
module prom_burner_chk #(
  parameter int ADDR_W = 16,
  parameter int PW_CYC = 20000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vcc_en,
  input logic              vpp_en,
  input logic              bus_oe,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr
);

  int   pw_cnt;
  logic in_pw;
  logic strobe;

  assign strobe = !mem_ce_n && mem_oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw_cnt <= 0;
      in_pw  <= 1'b0;
    end else begin
      in_pw  <= strobe;
      pw_cnt <= strobe ? pw_cnt + 1 : 0;
    end
  end

  AST_VPP_NEEDS_VCC: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_en |-> vcc_en); // R3

  AST_VCC_DROP_AFTER_VPP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vcc_en) |-> !$past(vpp_en)); // R3

  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_oe && !mem_oe_n)); // R7

  AST_READ_WITHOUT_VPP: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !vpp_en); // R7

  AST_STROBE_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (vpp_en && bus_oe)); // R5

  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pw && !strobe) |-> (pw_cnt == PW_CYC)); // R5

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_addr)); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!vcc_en && !vpp_en && !bus_oe && mem_ce_n && mem_oe_n)); // R1

endmodule

bind prom_burner prom_burner_chk #(
  .ADDR_W(ADDR_W),
  .PW_CYC(PULSE_US * TICKS_PER_US)
) u_chk (
  .clk(clk), .rst_n(rst_n), .vcc_en(vcc_en), .vpp_en(vpp_en),
  .bus_oe(bus_oe), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
  .busy(busy), .done(done), .mem_addr(mem_addr)
);

// File: tb/sim_prom_burner.sv
`timescale 1ns/1ps
module sim_prom_burner;
  localparam int AW = 8, TPU = 4, MAXT = 3;
  localparam int E_SET = 1 * TPU, E_PW = 100 * TPU, E_HLD = 1 * TPU, E_REC = 1 * TPU;
  localparam int E_VFY = (250 * TPU + 999) / 1000 + 1;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] addr = 0, mem_addr;
  logic [7:0] wdata = 0, mem_din, mem_dout;
  logic bus_oe, mem_ce_n, mem_oe_n, vcc_en, vpp_en, busy, done, err;

  always #2.5 clk = ~clk;

  prom_burner #(.ADDR_W(AW), .TICKS_PER_US(TPU), .MAX_TRIES(MAXT)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .wdata(wdata),
    .mem_din(mem_din), .mem_addr(mem_addr), .mem_dout(mem_dout), .bus_oe(bus_oe),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .vcc_en(vcc_en), .vpp_en(vpp_en),
    .busy(busy), .done(done), .err(err));

  logic [7:0] mem [256];
  assign mem_din = (!mem_ce_n && !mem_oe_n) ? mem[mem_addr] : 8'h00;

  int nvec = 0, nbad = 0, cycles = 0;
  int cur_need = 1, op_pulses = 0;
  bit first_vpp = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_err(input logic [7:0] old, input logic [7:0] d, input int need);
    return !(need <= MAXT && ((old & d) == d));
  endfunction

  // monitor
  logic p_ce = 1, p_oe = 1, p_vpp = 0, p_vcc = 0, p_doe = 0;
  int hi_cnt = 0, rec_cnt = 0, vfy_cnt = 0, pw_cnt = 0;
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (p_ce && !mem_ce_n && mem_oe_n) begin
        chk(hi_cnt == E_SET, "R4 setup", hi_cnt, E_SET);
        op_pulses++;
      end
      if (!p_ce && p_oe && mem_ce_n) begin
        chk(pw_cnt == E_PW, "R5 width", pw_cnt, E_PW);
        if (op_pulses >= cur_need) mem[mem_addr] = mem[mem_addr] & mem_dout;
      end
      if (p_doe && !bus_oe) chk(hi_cnt == E_HLD, "R6 hold", hi_cnt, E_HLD);
      if (p_oe && !mem_oe_n) chk(rec_cnt == E_REC, "R7 recovery", rec_cnt, E_REC);
      if (!p_oe && mem_oe_n) chk(vfy_cnt == E_VFY, "R8 read", vfy_cnt, E_VFY);
      if (!p_vpp && vpp_en && first_vpp) begin
        chk(rec_cnt == E_SET, "R3 vcc lead", rec_cnt, E_SET);
        first_vpp = 0;
      end
      if (p_vcc && !vcc_en) chk(!p_vpp && !vpp_en, "R3 vcc trail", vpp_en, 0);
      hi_cnt  = (bus_oe && mem_ce_n) ? hi_cnt + 1 : 0;
      rec_cnt = (vcc_en && !vpp_en && !bus_oe && mem_oe_n) ? rec_cnt + 1 : 0;
      vfy_cnt = (!mem_oe_n && !mem_ce_n) ? vfy_cnt + 1 : 0;
      pw_cnt  = (!mem_ce_n && mem_oe_n) ? pw_cnt + 1 : 0;
    end
    p_ce = mem_ce_n; p_oe = mem_oe_n; p_vpp = vpp_en; p_vcc = vcc_en; p_doe = bus_oe;
    if (cycles > 190000) begin
      nbad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  task automatic run_op(input logic [7:0] a, input logic [7:0] d, input int need, input bit intrude);
    logic [7:0] old, other;
    bit e;
    int w;
    old = mem[a];
    other = mem[~a];
    cur_need = need;
    op_pulses = 0;
    first_vpp = 1;
    e = exp_err(old, d, need);
    @(negedge clk); addr = a; wdata = d; start = 1;
    @(negedge clk); start = 0;
    chk(busy && mem_addr == a && mem_dout == d, "R2 capture", mem_addr, a);
    chk(!err, "R10 err cleared", err, 0);
    if (intrude) begin
      repeat (30) @(negedge clk);
      addr = ~a; wdata = ~d; start = 1;
      @(negedge clk); start = 0;
      chk(mem_addr == a && mem_dout == d, "R2 ignore start", mem_addr, a);
    end
    w = 0;
    while (!done && w < 5000) begin @(negedge clk); w++; end
    chk(done, "R10 done", done, 1);
    chk(err == e, "R10 err", err, e);
    chk(op_pulses == (e ? MAXT : need), "R9 strobes", op_pulses, e ? MAXT : need);
    chk(mem[a] == ((need <= MAXT) ? (old & d) : old), "R9 content", mem[a], old & d);
    @(negedge clk);
    chk(!done && !busy && !vcc_en, "R10 single done", done, 0);
    repeat (3) @(negedge clk);
    chk(err == e, "R10 err held", err, e);
    if (intrude) chk(mem[~a] == other, "R2 no second op", mem[~a], other);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    chk(!vcc_en && !vpp_en && !bus_oe && mem_ce_n && mem_oe_n && !busy && !done && !err,
        "R1 reset", {vcc_en, vpp_en, bus_oe, busy}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!busy && mem_ce_n && mem_oe_n, "R1 idle", busy, 0);
    run_op(8'h10, 8'hA5, 1, 0);
    run_op(8'h11, 8'h3C, MAXT, 0);
    run_op(8'h12, 8'h00, MAXT + 1, 0);
    mem[8'h13] = 8'h0F;
    run_op(8'h13, 8'hF0, 1, 0);
    run_op(8'h14, 8'h5A, 2, 1);
    for (int k = 0; k < 30; k++) begin
      logic [7:0] a;
      a = 8'($urandom_range(32, 255));
      if ($urandom_range(0, 3) == 0) mem[a] = 8'($urandom);
      run_op(a, 8'($urandom), int'($urandom_range(1, MAXT + 1)), ($urandom_range(0, 4) == 0));
    end
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule